// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets an 8-bit host bus reach up to 64 internal registers through two host-visible registers. The control register carries a 6-bit register index, a stream-mode flag and a busy flag. The data register is a window onto the internal register chosen by the index.

A host write to the data register becomes a one-cycle write strobe on the internal port, addressed by the current index. A read is split into two steps. The host first starts a fetch by writing the busy flag as 1. It then polls the control register until the busy flag drops, and reads the fetched value from the data register.

In stream mode, every host read of the data register starts the next fetch at the same index. A FIFO-type register can therefore be drained with one data read and one poll per entry. Each fetch gives exactly one read request pulse on the internal port, so a FIFO pops one entry per fetch. The internal port answers each request with an acknowledge 1 to 4 cycles later.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the control register at host address 0x96 reads 0x00, the data register at host address 0x97 reads 0x00, and neither internal strobe is active.
- R2: A host write to 0x96 stores bits 5:0 as the index and bit 6 as the stream-mode flag. A read of 0x96 returns busy in bit 7, stream mode in bit 6 and the index in bits 5:0.
- R3: A host write to 0x96 with bit 7 set while idle starts a fetch. On the next cycle bit 7 reads 1 and `core_rd_req` is high for one cycle, with `core_raddr` equal to the index that was written.
- R4: Busy stays 1 until the cycle in which `core_rd_ack` is high. It clears on the next edge, and the data register then holds the `core_rdata` value that came with the acknowledge.
- R5: A host write to 0x96 with bit 7 clear starts no fetch and leaves the data register unchanged.
- R6: A host write to 0x97 produces exactly one `core_wr` pulse on the next cycle, carrying the current index on `core_waddr` and the written byte on `core_wdata`.
- R7: With stream mode set and the bridge idle, a host read of 0x97 starts a new fetch at the current index, and the index does not change.
- R8: With stream mode clear, a host read of 0x97 starts no fetch.
- R9: While a fetch is in progress, a further start request is ignored. This holds whether it comes from a busy write or from a stream-mode data read. The running fetch completes with the index sampled at its launch, even if the host has since changed the index.
- R10: Each fetch issues exactly one `core_rd_req` pulse, so a FIFO-type register behind the bridge gives up exactly one entry per fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from address |
| core_wr | output | 1 | Internal write strobe, one cycle |
| core_waddr | output | 6 | Internal write index |
| core_wdata | output | 8 | Internal write data |
| core_rd_req | output | 1 | Internal read request / pop strobe, one cycle |
| core_raddr | output | 6 | Internal read index, sampled at launch |
| core_rd_ack | input | 1 | Internal read acknowledge |
| core_rdata | input | 8 | Internal read data, valid with acknowledge |

## Verification
The bench goes after several corner cases. One is a start request that arrives while a fetch is still running, together with an index change. A bridge that re-launches would pop a FIFO twice, and one that resamples the index would return the wrong register. It also checks stream-mode reads made while busy, which must not start a second fetch. Another case is writes with the busy bit clear, where a wrong decode would issue spurious read requests. Internal latency is randomized from 1 to 4 cycles. A bridge that drops busy before the acknowledge would hand back stale data, and one that fails to pop once per fetch would give FIFO values out of sequence.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int IDX_W    = 6;
  localparam int BYTE_W   = 8;
  localparam int BUSY_POS = 7;
  localparam int MODE_POS = 6;

  // Assemble the control register read value.
  function automatic logic [BYTE_W-1:0] pack_ctrl(input logic busy,
                                                  input logic mode,
                                                  input logic [IDX_W-1:0] idx);
    return {busy, mode, idx};
  endfunction

  // True when a control write asks for a fetch.
  function automatic logic wants_fetch(input logic [BYTE_W-1:0] wd);
    return wd[BUSY_POS];
  endfunction
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode #(
  parameter int          HADDR_W   = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h96,
  parameter logic [7:0]  DATA_ADDR = 8'h97
) (
  input  logic [HADDR_W-1:0] addr,
  input  logic               wr,
  input  logic               rd,
  output logic               ctrl_hit,
  output logic               ctrl_wr,
  output logic               data_hit,
  output logic               data_wr,
  output logic               data_rd
);
  always_comb begin
    ctrl_hit = (addr == HADDR_W'(CTRL_ADDR));
    data_hit = (addr == HADDR_W'(DATA_ADDR));
    ctrl_wr  = ctrl_hit && wr;
    data_wr  = data_hit && wr;
    data_rd  = data_hit && rd;
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      mode <= 1'b0;
    end else if (ctrl_wr) begin
      idx  <= wdata[IDX_W-1:0];
      mode <= wdata[MODE_POS];
    end
  end
endmodule

// File: rtl/regwin_fetch.sv
module regwin_fetch
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [IDX_W-1:0]  launch_idx,
  input  logic              ack,
  input  logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              req,
  output logic [IDX_W-1:0]  raddr,
  output logic [BYTE_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      req    <= 1'b0;
      raddr  <= '0;
      data_q <= '0;
    end else begin
      req <= launch;
      if (launch) begin
        busy  <= 1'b1;
        raddr <= launch_idx;
      end else if (busy && ack) begin
        busy   <= 1'b0;
        data_q <= rdata;
      end
    end
  end
endmodule

// File: rtl/regwin_wpath.sv
module regwin_wpath
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic              wr,
  output logic [IDX_W-1:0]  waddr,
  output logic [BYTE_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr      <= 1'b0;
      waddr   <= '0;
      wdata_q <= '0;
    end else begin
      wr <= data_wr;
      if (data_wr) begin
        waddr   <= idx;
        wdata_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int         HADDR_W   = 8,
  parameter logic [7:0] CTRL_ADDR = 8'h96,
  parameter logic [7:0] DATA_ADDR = 8'h97
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               core_wr,
  output logic [5:0]         core_waddr,
  output logic [7:0]         core_wdata,
  output logic               core_rd_req,
  output logic [5:0]         core_raddr,
  input  logic               core_rd_ack,
  input  logic [7:0]         core_rdata
);
  // Named internal events, visible to the bound checker.
  logic              ctrl_hit_w, data_hit_w;
  logic              ctrl_wr_w, data_wr_w, data_rd_w;
  logic [IDX_W-1:0]  idx_w;
  logic              mode_w;
  logic              busy_w;
  logic [BYTE_W-1:0] data_q_w;
  logic              start_req_w;
  logic              launch_w;
  logic [IDX_W-1:0]  launch_idx_w;

  regwin_decode #(
    .HADDR_W(HADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .ctrl_hit(ctrl_hit_w), .ctrl_wr(ctrl_wr_w),
    .data_hit(data_hit_w), .data_wr(data_wr_w), .data_rd(data_rd_w)
  );

  regwin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr_w), .wdata(host_wdata),
    .idx(idx_w), .mode(mode_w)
  );

  // A start comes from a busy write or a stream-mode data read; busy blocks both.
  assign start_req_w  = (ctrl_wr_w && wants_fetch(host_wdata)) || (data_rd_w && mode_w);
  assign launch_w     = start_req_w && !busy_w;
  assign launch_idx_w = ctrl_wr_w ? host_wdata[IDX_W-1:0] : idx_w;

  regwin_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .launch_idx(launch_idx_w),
    .ack(core_rd_ack), .rdata(core_rdata),
    .busy(busy_w), .req(core_rd_req), .raddr(core_raddr), .data_q(data_q_w)
  );

  regwin_wpath u_wpath (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr_w), .idx(idx_w), .wdata(host_wdata),
    .wr(core_wr), .waddr(core_waddr), .wdata_q(core_wdata)
  );

  always_comb begin
    if (ctrl_hit_w)      host_rdata = pack_ctrl(busy_w, mode_w, idx_w);
    else if (data_hit_w) host_rdata = data_q_w;
    else                 host_rdata = '0;
  end
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       launch,
  input logic       start_req,
  input logic       ctrl_wr,
  input logic       data_wr,
  input logic       data_rd,
  input logic       mode,
  input logic [5:0] idx,
  input logic       core_wr,
  input logic [5:0] core_waddr,
  input logic       core_rd_req,
  input logic       core_rd_ack
);
  assert_launch_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (core_rd_req && busy));

  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_rd_ack) |=> !busy);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_rd_ack) |=> busy);

  assert_wr_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (core_wr && core_waddr == $past(idx)));

  assert_stream_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && mode && !busy) |-> launch);

  assert_no_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !mode && !ctrl_wr) |=> !core_rd_req);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> !core_rd_req);

  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd_req |=> !core_rd_req);
endmodule

bind regwin_bridge regwin_bridge_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .launch(launch_w),
  .start_req(start_req_w), .ctrl_wr(ctrl_wr_w), .data_wr(data_wr_w),
  .data_rd(data_rd_w), .mode(mode_w), .idx(idx_w), .core_wr(core_wr),
  .core_waddr(core_waddr), .core_rd_req(core_rd_req), .core_rd_ack(core_rd_ack)
);

// File: tb/test_regwin_bridge.sv
module test_regwin_bridge;
  localparam logic [7:0] A_CTRL   = 8'h96;
  localparam logic [7:0] A_DATA   = 8'h97;
  localparam logic [5:0] FIFO_IDX = 6'h2A;
  localparam logic [7:0] FIFO_BASE = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       core_wr, core_rd_req;
  logic [5:0] core_waddr, core_raddr;
  logic [7:0] core_wdata;
  logic       core_rd_ack = 1'b0;
  logic [7:0] core_rdata = '0;

  always #5 clk = ~clk;

  regwin_bridge i_regwin_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_wr(core_wr), .core_waddr(core_waddr), .core_wdata(core_wdata),
    .core_rd_req(core_rd_req), .core_raddr(core_raddr),
    .core_rd_ack(core_rd_ack), .core_rdata(core_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int n_req = 0, n_wr = 0, n_pop = 0;
  int force_lat = 0;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7 + 3) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] ctrl_word(input bit b, input bit m, input logic [5:0] ix);
    return (8'(b) << 7) | (8'(m) << 6) | 8'(ix);
  endfunction

  // Peripheral model: storage, FIFO, variable-latency responder.
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  bit         pend = 0;
  int         cnt = 0;
  logic [5:0] p_addr = '0;
  logic [7:0] p_data = '0;

  initial for (int i = 0; i < 64; i++) begin mem[i] = init_val(i); shadow[i] = init_val(i); end

  always @(negedge clk) begin
    core_rd_ack <= 1'b0;
    if (core_wr) begin n_wr++; mem[core_waddr] = core_wdata; end
    if (pend) begin
      if (cnt == 1) begin core_rd_ack <= 1'b1; core_rdata <= p_data; pend = 0; end
      else cnt--;
    end
    if (core_rd_req) begin
      n_req++;
      pend = 1;
      cnt = (force_lat != 0) ? force_lat : int'($urandom_range(1, 4));
      p_addr = core_raddr;
      if (core_raddr == FIFO_IDX) begin p_data = FIFO_BASE + 8'(n_pop); n_pop++; end
      else p_data = mem[core_raddr];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic poll(input string req);
    logic [7:0] v;
    int n = 0;
    do begin hread(A_CTRL, v); n++; end while (v[7] && n < 20);
    check(req, 32'(v[7]), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [7:0] v;
    int r0, w0;
    void'($urandom(32'd1307));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    hread(A_CTRL, v); check("R1 ctrl", v, 8'h00);
    hread(A_DATA, v); check("R1 data", v, 8'h00);
    check("R1 strobes", 32'(core_wr | core_rd_req), 0);

    // R2 readback of index and mode
    hwrite(A_CTRL, ctrl_word(0, 1, 6'h15)); hread(A_CTRL, v);
    check("R2 readback", v, ctrl_word(0, 1, 6'h15));
    hwrite(A_CTRL, ctrl_word(0, 0, 6'h03)); hread(A_CTRL, v);
    check("R2 readback2", v, ctrl_word(0, 0, 6'h03));

    // R3/R4 directed fetch with max latency
    force_lat = 4; r0 = n_req;
    @(negedge clk); host_addr = A_CTRL; host_wdata = ctrl_word(1, 0, 6'h09); host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0; #1;
    check("R3 busy set", 32'(host_rdata[7]), 1);
    check("R3 req", 32'(core_rd_req), 1);
    check("R3 raddr", 32'(core_raddr), 32'h09);
    poll("R4 busy clear");
    hread(A_DATA, v); check("R4 data", v, shadow[9]);
    check("R10 one req", n_req - r0, 1);

    // R5 busy=0 write starts nothing
    r0 = n_req;
    hwrite(A_CTRL, ctrl_word(0, 0, 6'h11));
    repeat (6) @(negedge clk);
    check("R5 no req", n_req - r0, 0);
    hread(A_DATA, v); check("R5 data kept", v, shadow[9]);

    // R6 write path
    w0 = n_wr;
    hwrite(A_DATA, 8'hC3); shadow[6'h11] = 8'hC3;
    @(negedge clk);
    check("R6 one wr", n_wr - w0, 1);
    check("R6 stored", mem[6'h11], 8'hC3);

    // R9 start while busy ignored, index sampled at launch
    r0 = n_req;
    hwrite(A_CTRL, ctrl_word(1, 0, 6'h11));
    hwrite(A_CTRL, ctrl_word(1, 0, 6'h20));
    poll("R9 poll");
    hread(A_DATA, v); check("R9 old index data", v, shadow[6'h11]);
    check("R9 one req", n_req - r0, 1);
    hread(A_CTRL, v); check("R9 index updated", v, ctrl_word(0, 0, 6'h20));

    // R7/R10 stream FIFO
    force_lat = 0; r0 = n_req;
    hwrite(A_CTRL, ctrl_word(1, 1, FIFO_IDX));
    for (int k = 0; k < 5; k++) begin
      poll("R7 poll");
      hread(A_DATA, v); check("R7 stream value", v, FIFO_BASE + 8'(k));
      hread(A_DATA, v); // while busy: must not pop again (R9)
    end
    poll("R7 final poll");
    check("R10 pops", n_pop, 6);
    check("R10 reqs", n_req - r0, 6);
    hread(A_CTRL, v); check("R7 index kept", v, ctrl_word(0, 1, FIFO_IDX));

    // R8 mode clear: data read starts nothing
    hwrite(A_CTRL, ctrl_word(0, 0, FIFO_IDX));
    r0 = n_req;
    hread(A_DATA, v); hread(A_DATA, v);
    repeat (6) @(negedge clk);
    check("R8 no req", n_req - r0, 0);
    check("R8 data", v, FIFO_BASE + 8'd5);

    // Random write/fetch traffic (R4, R6)
    for (int it = 0; it < 40; it++) begin
      logic [5:0] ix;
      logic [7:0] d;
      ix = 6'($urandom_range(0, 63));
      if (ix == FIFO_IDX) ix = 6'h00;
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        hwrite(A_CTRL, ctrl_word(0, 0, ix));
        hwrite(A_DATA, d); shadow[ix] = d;
      end
      hwrite(A_CTRL, ctrl_word(1, 0, ix));
      poll("R4 rand poll");
      hread(A_DATA, v); check("R4 rand data", v, shadow[ix]);
    end
    summary();
  end
endmodule